// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the timing strobes of a serial port from a fast bus clock. A 16-bit divider word sets the length of one sample interval as a fixed-point number of clocks: an integer mantissa plus a fraction. The block emits a one-clock `sample_tick` at the end of every sample interval. It also emits a one-clock `bit_tick` on every 16th or 8th sample tick, so a bit lasts 16 or 8 sample intervals. One divider setting serves the transmitter and the receiver alike; both consume the same two strobes.

The fraction is spread over successive intervals by an accumulator. Each interval lasts either the mantissa or the mantissa plus one clock, so the average interval length matches the programmed ratio. The oversampling select picks the bit length and, with it, the fraction resolution: sixteenths in 16x mode, eighths in 8x mode. When `enable` is low the block holds its counters and accumulator cleared and produces nothing. The next rise of `enable` therefore starts a fresh, predictable tick sequence.

No data stream passes through the block, so there is no valid/ready handshake. All pins are plain control inputs and strobe outputs.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low, and after its release until `enable` rises, `sample_tick` and `bit_tick` are both 0.
- R2: While `enable` is low, no tick of either kind is produced. The interval counter, fraction accumulator and sample counter restart from zero, so each rise of `enable` begins the sequence of R3/R4 anew.
- R3: `div_word[15:4]` is the mantissa M and `div_word[3:0]` is the fraction F. With `os8_sel`=0, the n-th sample tick is high in the clock that follows the (n*M + floor(n*F/16))-th rising edge with `enable` high.
- R4: With `os8_sel`=1, `div_word[3]` is ignored and the fraction is F8=`div_word[2:0]`. The n-th sample tick falls after n*M + floor(n*F8/8) enabled edges.
- R5: Every sample interval lasts M or M+1 clocks. An extra clock is added exactly when the fraction accumulator overflows. For M of 2 or more, a sample tick is never high on two consecutive clocks.
- R6: A divider value below 1.0 (M = 0) is treated as exactly 1.0. The fraction is then ignored and `sample_tick` is high on every enabled clock.
- R7: With M=1, F=0 and `os8_sel`=1, a sample tick occurs every clock and a bit tick every 8 clocks. This is the highest bit rate, one eighth of the clock rate.
- R8: `bit_tick` is high together with the 16th, 32nd, ... sample tick after `enable` rises when `os8_sel`=0, and with the 8th, 16th, ... when `os8_sel`=1.
- R9: `bit_tick` is never high in a clock where `sample_tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the generator; low clears state and stops ticks |
| div_word | input | 16 | Divider: mantissa in [15:4], fraction in [3:0] |
| os8_sel | input | 1 | 0 = 16 samples per bit, 1 = 8 samples per bit |
| sample_tick | output | 1 | One-clock strobe per sample interval |
| bit_tick | output | 1 | One-clock strobe per bit period, coincident with a sample tick |

## Verification
The assertions judge each interval against the divider and mode present in the clock of the preceding tick. They therefore take for granted that `div_word` and `os8_sel` do not move in the middle of an interval whose behaviour is being compared with a model. The stimulus honours this by changing the divider and mode only while `enable` is low, then raising `enable` for a run of known length. During the low phases it deliberately moves the divider and mode to confirm that nothing is emitted.

// File: rtl/baud_pkg.sv
`timescale 1ns/1ps
package baud_pkg;
  // default field widths of the divider word
  localparam int MANT_W_DEF = 12;
  localparam int FRAC_W_DEF = 4;
endpackage

// File: rtl/baud_div_decode.sv
`timescale 1ns/1ps
// Splits the divider word, drops the fraction MSB in 8x mode and clamps
// ratios below 1.0 up to exactly 1.0.
module baud_div_decode #(
  parameter int MANT_W = 12,
  parameter int FRAC_W = 4
) (
  input  logic [MANT_W+FRAC_W-1:0] div_word,
  input  logic                     os8_sel,
  output logic [MANT_W-1:0]        mant_eff,
  output logic [FRAC_W-1:0]        frac_eff
);
  logic [MANT_W-1:0] mant_raw;
  logic [FRAC_W-1:0] frac_raw;
  logic [FRAC_W-1:0] frac_keep;

  assign mant_raw = div_word[MANT_W+FRAC_W-1:FRAC_W];
  assign frac_raw = div_word[FRAC_W-1:0];

  // in 8x mode the fraction has one bit less resolution
  for (genvar gi = 0; gi < FRAC_W; gi++) begin : g_mask
    if (gi == FRAC_W-1) begin : g_top
      assign frac_keep[gi] = frac_raw[gi] & ~os8_sel;
    end else begin : g_low
      assign frac_keep[gi] = frac_raw[gi];
    end
  end

  always_comb begin
    if (mant_raw == '0) begin
      mant_eff = MANT_W'(1);
      frac_eff = '0;
    end else begin
      mant_eff = mant_raw;
      frac_eff = frac_keep;
    end
  end
endmodule

// File: rtl/baud_frac_acc.sv
`timescale 1ns/1ps
// Counts clocks of one sample interval; the interval is stretched by one
// clock whenever the fraction accumulator wraps.
module baud_frac_acc #(
  parameter int MANT_W = 12,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              os8_sel,
  input  logic [MANT_W-1:0] mant_eff,
  input  logic [FRAC_W-1:0] frac_eff,
  output logic              samp_pulse,
  output logic              samp_q
);
  localparam int LEN_W = MANT_W + 1;

  logic [LEN_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  len;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W-1:0] acc_in;
  logic [FRAC_W-1:0] acc_nxt;
  logic [FRAC_W:0]   sum;
  logic              carry;

  always_comb begin
    acc_in = acc_q;
    if (os8_sel) acc_in[FRAC_W-1] = 1'b0;
    sum = {1'b0, acc_in} + {1'b0, frac_eff};
    if (os8_sel) begin
      carry   = sum[FRAC_W-1];
      acc_nxt = {1'b0, sum[FRAC_W-2:0]};
    end else begin
      carry   = sum[FRAC_W];
      acc_nxt = sum[FRAC_W-1:0];
    end
    len        = {1'b0, mant_eff} + LEN_W'(carry);
    // >= keeps the counter bounded if the divider shrinks mid-interval
    samp_pulse = enable && ((cnt_q + LEN_W'(1)) >= len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      samp_q <= 1'b0;
    end else if (!enable) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      samp_q <= 1'b0;
    end else if (samp_pulse) begin
      cnt_q  <= '0;
      acc_q  <= acc_nxt;
      samp_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + LEN_W'(1);
      samp_q <= 1'b0;
    end
  end

  // R5: an interval is never shorter than the mantissa
  a_r5_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_q && enable && mant_eff > MANT_W'(1)) |=> !samp_q);

  // R2: a tick always starts a fresh interval count
  a_r2_restart_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    samp_q |-> (cnt_q == '0));
endmodule

// File: rtl/baud_bit_slicer.sv
`timescale 1ns/1ps
// Counts sample strobes and marks the last one of each bit period.
module baud_bit_slicer #(
  parameter int FRAC_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic os8_sel,
  input  logic samp_pulse,
  output logic bit_q
);
  localparam logic [FRAC_W-1:0] WRAP_HI = '1;
  localparam logic [FRAC_W-1:0] WRAP_LO = FRAC_W'((1 << (FRAC_W-1)) - 1);

  logic [FRAC_W-1:0] scnt_q;
  logic [FRAC_W-1:0] wrap_at;
  logic              last;

  always_comb begin
    wrap_at = os8_sel ? WRAP_LO : WRAP_HI;
    last    = samp_pulse && (scnt_q >= wrap_at);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt_q <= '0;
      bit_q  <= 1'b0;
    end else if (!enable) begin
      scnt_q <= '0;
      bit_q  <= 1'b0;
    end else if (samp_pulse) begin
      scnt_q <= last ? '0 : scnt_q + FRAC_W'(1);
      bit_q  <= last;
    end else begin
      bit_q  <= 1'b0;
    end
  end

  // R8: after a bit strobe the sample count begins again at zero
  a_r8_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q |-> (scnt_q == '0));
endmodule

// File: rtl/baud_tick_gen.sv
`timescale 1ns/1ps
module baud_tick_gen #(
  parameter int MANT_W = baud_pkg::MANT_W_DEF,
  parameter int FRAC_W = baud_pkg::FRAC_W_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic [MANT_W+FRAC_W-1:0] div_word,
  input  logic                     os8_sel,
  output logic                     sample_tick,
  output logic                     bit_tick
);
  logic [MANT_W-1:0] mant_eff;
  logic [FRAC_W-1:0] frac_eff;
  logic              samp_pulse;
  logic              samp_q;
  logic              bit_q;

  baud_div_decode #(.MANT_W(MANT_W), .FRAC_W(FRAC_W)) u_decode (
    .div_word (div_word),
    .os8_sel  (os8_sel),
    .mant_eff (mant_eff),
    .frac_eff (frac_eff)
  );

  baud_frac_acc #(.MANT_W(MANT_W), .FRAC_W(FRAC_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .os8_sel    (os8_sel),
    .mant_eff   (mant_eff),
    .frac_eff   (frac_eff),
    .samp_pulse (samp_pulse),
    .samp_q     (samp_q)
  );

  baud_bit_slicer #(.FRAC_W(FRAC_W)) u_slicer (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .os8_sel    (os8_sel),
    .samp_pulse (samp_pulse),
    .bit_q      (bit_q)
  );

  assign sample_tick = samp_q;
  assign bit_tick    = bit_q;

  // R9: a bit strobe is always also a sample strobe
  a_r9_bit_with_sample: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  // R2: a low enable silences both outputs on the next clock
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sample_tick && !bit_tick));

  // R6: a zero mantissa yields a tick on every enabled clock
  a_r6_clamp_every_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && div_word[MANT_W+FRAC_W-1:FRAC_W] == '0) |=> sample_tick);
endmodule

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;
  typedef struct {
    int t;
    bit b;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] div_word = '0;
  logic        os8_sel = 1'b0;
  logic        sample_tick;
  logic        bit_tick;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";
  exp_t  q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  baud_tick_gen u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .div_word    (div_word),
    .os8_sel     (os8_sel),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected ticks as the design emits them
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && !done) begin
      if (sample_tick) begin
        if (q.size() == 0) begin
          check(1'b0, "R2", "sample tick with none expected, cycle", cyc, -1);
        end else begin
          e = q.pop_front();
          check(cyc == e.t, cur_tag, "sample tick cycle", cyc, e.t);
          check(bit_tick == e.b, "R8", "bit tick with sample", int'(bit_tick), int'(e.b));
        end
      end else if (bit_tick) begin
        check(1'b0, "R9", "bit tick without sample tick", 1, 0);
      end
    end
  end

  // driver: programs a divider, predicts every tick, runs to the last one
  task automatic run_case(input int mant, input int frac, input bit os8,
                          input int k, input string tag);
    int start, m_eff, f_eff, den, nb, last;
    @(posedge clk); #1;
    div_word = {mant[11:0], frac[3:0]};
    os8_sel  = os8;
    cur_tag  = tag;
    enable   = 1'b1;
    start    = cyc;
    m_eff    = (mant == 0) ? 1 : mant;
    f_eff    = (mant == 0) ? 0 : (os8 ? (frac & 7) : frac);
    den      = os8 ? 8 : 16;
    nb       = os8 ? 8 : 16;
    for (int n = 1; n <= k; n++) begin
      q.push_back('{start + n*m_eff + (n*f_eff)/den, (n % nb) == 0});
    end
    last = start + k*m_eff + (k*f_eff)/den;
    do begin
      @(posedge clk); #1;
    end while (cyc < last);
    enable = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(q.size() == 0, tag, "ticks still missing", q.size(), 0);
    q.delete();
    check(sample_tick == 1'b0 && bit_tick == 1'b0, "R2",
          "outputs after disable", int'(sample_tick) + int'(bit_tick), 0);
  endtask

  // enable stays low while divider and mode move: nothing may appear
  task automatic idle_scramble(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      div_word = 16'(i * 37);
      os8_sel  = i[0];
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sample_tick == 1'b0 && bit_tick == 1'b0, "R1", "outputs in reset",
          int'(sample_tick) + int'(bit_tick), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sample_tick == 1'b0 && bit_tick == 1'b0, "R1", "outputs after reset",
          int'(sample_tick) + int'(bit_tick), 0);

    run_case(1, 0, 1'b1, 32, "R7");   // top rate, 8x
    idle_scramble(20);
    run_case(4, 0, 1'b0, 32, "R3");   // integer ratio, 16x
    run_case(3, 5, 1'b0, 48, "R3");   // fractional, 16x
    run_case(3, 5, 1'b0, 48, "R2");   // same again: accumulator restarted
    run_case(5, 15, 1'b0, 32, "R5");  // fraction nearly one
    run_case(2, 11, 1'b1, 24, "R4");  // fraction bit 3 ignored in 8x
    run_case(7, 8, 1'b1, 16, "R4");   // only bit 3 set: integer in 8x
    idle_scramble(20);
    run_case(0, 7, 1'b0, 32, "R6");   // clamp to 1.0
    run_case(0, 9, 1'b1, 16, "R6");
    run_case(100, 9, 1'b0, 20, "R3"); // long interval
    idle_scramble(10);
    check(q.size() == 0, "R2", "queue after idle", q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule